// File: doc/BRIEF.md
# Shift-Then-Logic Bitwise Unit

This block is a purely combinational datapath. It shifts operand A by an amount taken from a shift operand, then merges the shifted value with operand B using AND, OR or XOR. Operand B can be bitwise inverted before the merge, and the merged value can be bitwise inverted on the way out. The shift is either left or logical right, so each bitwise operation comes in a left form and a right form, giving six in all.

The unit runs either as one 32-bit shifter or as two independent 16-bit lanes. In lane mode, a small selector picks which byte of the shift operand gives each lane its own shift amount. No bits cross the lane boundary.

With a zero shift amount and B tied to zero, the unit works as a plain move. Adding the output inversion turns it into a bitwise NOT.

Top module: `bsl_unit`

## Requirements
- R1: With `dir_right`=0, A is shifted left and the vacated low bits fill with zeros. In 32-bit mode (`dual16`=0) the shift amount is `op_sh[4:0]`.
- R2: With `dir_right`=1, A is shifted right logically and the vacated high bits fill with zeros.
- R3: `logic_op` selects the merge of the shifted A with the (possibly inverted) B: 2'b00 AND, 2'b01 OR, 2'b10 XOR. Code 2'b11 also gives XOR.
- R4: With `inv_b`=1, B is bitwise inverted before the merge.
- R5: With `inv_out`=1, the merged value is bitwise inverted to form `result`.
- R6: With `dual16`=1, bits [15:0] form lane 0 and bits [31:16] form lane 1. Each lane shifts by the low 4 bits of byte k of `op_sh` (byte k = `op_sh[8k+7:8k]`). For lane 0, k is `lane_bsel[1:0]`; for lane 1, k is `lane_bsel[3:2]`.
- R7: In 16-bit lane mode no bit of A crosses between the lanes, in either shift direction.
- R8: Bits of `op_sh` outside the selected amount field have no effect on `result`. In 32-bit mode these are bits [31:5]. In lane mode they are all bits outside the two selected 4-bit fields. In 32-bit mode `lane_bsel` has no effect.
- R9: With a zero shift amount, B=0, `logic_op`=OR and `inv_b`=0, `result` equals A. When `inv_out`=1 as well, `result` equals ~A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | Operand that is shifted |
| op_b | input | 32 | Operand merged with the shifted value |
| op_sh | input | 32 | Source of the shift amount(s) |
| dir_right | input | 1 | 1 = logical right shift, 0 = left shift |
| logic_op | input | 2 | Merge operation code |
| inv_b | input | 1 | Invert B before the merge |
| inv_out | input | 1 | Invert the merged value |
| dual16 | input | 1 | 1 = two 16-bit lanes, 0 = one 32-bit word |
| lane_bsel | input | 4 | Byte selectors for the lane shift amounts |
| result | output | 32 | Final value |

## Verification
The bench targets these corner cases:
- **Lane boundary.** It shifts all-ones patterns by 15 in lane mode, in both directions. A design that shifted the whole word would leak bits across bit 16.
- **Byte selectors.** It uses selectors that point the two lanes at different bytes, including the same byte for both and the cross pairing. A swapped or miswired selector gives each lane the wrong amount.
- **Amount field width.** It sets the high bits of the amount byte, which catches a design that takes the amount from the wrong field width.
- **Ordering and codes.** It checks the unused operation code, and it pairs B inversion with output inversion to expose designs that apply them in the wrong order.
- **Move and NOT.** It checks that the move and NOT forms return A and its complement exactly.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  typedef enum logic [1:0] {
    LOP_AND  = 2'b00,
    LOP_OR   = 2'b01,
    LOP_XOR  = 2'b10,
    LOP_XORA = 2'b11
  } lop_e;
endpackage

// File: rtl/bsl_amt_sel.sv
module bsl_amt_sel #(
  parameter int DATA_W  = 32,
  parameter int LANE_W  = 16,
  parameter int LANES   = DATA_W / LANE_W,
  parameter int BSEL_W  = $clog2(DATA_W / 8),
  parameter int FULL_AW = $clog2(DATA_W),
  parameter int LANE_AW = $clog2(LANE_W)
) (
  input  logic [DATA_W-1:0]         sh_src,
  input  logic [LANES*BSEL_W-1:0]   bsel,
  output logic [FULL_AW-1:0]        full_amt,
  output logic [LANES*LANE_AW-1:0]  lane_amt
);
  // Word mode takes its amount from the low bits of byte 0.
  assign full_amt = sh_src[FULL_AW-1:0];

  // Each lane picks one byte and keeps only its low bits.
  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [BSEL_W-1:0] idx;
      assign idx = bsel[l*BSEL_W +: BSEL_W];
      assign lane_amt[l*LANE_AW +: LANE_AW] = sh_src[idx*8 +: LANE_AW];
    end
  endgenerate
endmodule

// File: rtl/bsl_shifter.sv
module bsl_shifter #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          right,
  output logic [W-1:0]  dout
);
  always_comb begin
    if (right) dout = din >> amt;
    else       dout = din << amt;
  end

  // Immediate checks next to the shifter.
  always_comb begin
    if (amt == '0)
      p_zero_amt_passthru_r9: assert (dout == din);
    if (right && amt != '0)
      p_right_zero_fill_r2: assert (dout[W-1] == 1'b0);
    if (!right && amt != '0)
      p_left_zero_fill_r1: assert (dout[0] == 1'b0);
  end
endmodule

// File: rtl/bsl_combine.sv
module bsl_combine
  import bsl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] shv,
  input  logic [W-1:0] b,
  input  lop_e         op,
  input  logic         inv_b,
  input  logic         inv_out,
  output logic [W-1:0] res
);
  logic [W-1:0] b_eff;
  logic [W-1:0] merged;

  assign b_eff = inv_b ? ~b : b;

  always_comb begin
    unique case (op)
      LOP_AND: merged = shv & b_eff;
      LOP_OR:  merged = shv | b_eff;
      default: merged = shv ^ b_eff;
    endcase
  end

  assign res = inv_out ? ~merged : merged;

  always_comb begin
    if (op == LOP_AND && !inv_b && !inv_out)
      p_and_masks_r3: assert ((res & ~b) == '0);
    if (op == LOP_AND && inv_b && !inv_out)
      p_inv_b_masks_r4: assert ((res & b) == '0);
    if (op == LOP_OR && !inv_b && inv_out)
      p_inv_out_clears_r5: assert ((res & b) == '0);
  end
endmodule

// File: rtl/bsl_unit.sv
module bsl_unit
  import bsl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LANE_W  = 16,
  localparam int LANES   = DATA_W / LANE_W,
  localparam int BSEL_W  = $clog2(DATA_W / 8),
  localparam int FULL_AW = $clog2(DATA_W),
  localparam int LANE_AW = $clog2(LANE_W)
) (
  input  logic [DATA_W-1:0]       op_a,
  input  logic [DATA_W-1:0]       op_b,
  input  logic [DATA_W-1:0]       op_sh,
  input  logic                    dir_right,
  input  logic [1:0]              logic_op,
  input  logic                    inv_b,
  input  logic                    inv_out,
  input  logic                    dual16,
  input  logic [LANES*BSEL_W-1:0] lane_bsel,
  output logic [DATA_W-1:0]       result
);
  logic [FULL_AW-1:0]       full_amt;
  logic [LANES*LANE_AW-1:0] lane_amt;
  logic [DATA_W-1:0]        sh_full;
  logic [DATA_W-1:0]        sh_lane;
  logic [DATA_W-1:0]        sh_sel;

  bsl_amt_sel #(
    .DATA_W(DATA_W), .LANE_W(LANE_W)
  ) u_amt (
    .sh_src  (op_sh),
    .bsel    (lane_bsel),
    .full_amt(full_amt),
    .lane_amt(lane_amt)
  );

  bsl_shifter #(.W(DATA_W), .AW(FULL_AW)) u_full (
    .din  (op_a),
    .amt  (full_amt),
    .right(dir_right),
    .dout (sh_full)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      bsl_shifter #(.W(LANE_W), .AW(LANE_AW)) u_lane (
        .din  (op_a[l*LANE_W +: LANE_W]),
        .amt  (lane_amt[l*LANE_AW +: LANE_AW]),
        .right(dir_right),
        .dout (sh_lane[l*LANE_W +: LANE_W])
      );
    end
  endgenerate

  assign sh_sel = dual16 ? sh_lane : sh_full;

  bsl_combine #(.W(DATA_W)) u_comb (
    .shv    (sh_sel),
    .b      (op_b),
    .op     (lop_e'(logic_op)),
    .inv_b  (inv_b),
    .inv_out(inv_out),
    .res    (result)
  );

  always_comb begin
    if (!dual16 && full_amt == '0 && op_b == '0 && logic_op == 2'b01 && !inv_b)
      p_move_or_not_r9: assert (result == (inv_out ? ~op_a : op_a));
  end
endmodule

// File: tb/bsl_unit_bench.sv
module bsl_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] op_a, op_b, op_sh;
  logic        dir_right, inv_b, inv_out, dual16;
  logic [1:0]  logic_op;
  logic [3:0]  lane_bsel;
  logic [31:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsl_unit u_bsl_unit (
    .op_a(op_a), .op_b(op_b), .op_sh(op_sh), .dir_right(dir_right),
    .logic_op(logic_op), .inv_b(inv_b), .inv_out(inv_out),
    .dual16(dual16), .lane_bsel(lane_bsel), .result(result)
  );

  function automatic logic [15:0] sh16(logic [15:0] v, int n, bit r);
    return r ? (v >> n) : (v << n);
  endfunction

  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b,
      logic [31:0] s, bit r, logic [1:0] op, bit ib, bit io, bit d,
      logic [3:0] bs);
    logic [31:0] shv, be, m;
    if (!d) begin
      shv = r ? (a >> s[4:0]) : (a << s[4:0]);
    end else begin
      int k0 = int'(bs[1:0]);
      int k1 = int'(bs[3:2]);
      int n0 = int'(s[k0*8 +: 4]);
      int n1 = int'(s[k1*8 +: 4]);
      shv[15:0]  = sh16(a[15:0],  n0, r);
      shv[31:16] = sh16(a[31:16], n1, r);
    end
    be = ib ? ~b : b;
    case (op)
      2'b00:   m = shv & be;
      2'b01:   m = shv | be;
      default: m = shv ^ be;
    endcase
    return io ? ~m : m;
  endfunction

  task automatic apply_check(string tag, logic [31:0] a, logic [31:0] b,
      logic [31:0] s, bit r, logic [1:0] op, bit ib, bit io, bit d,
      logic [3:0] bs);
    logic [31:0] exp;
    @(negedge clk);
    op_a = a; op_b = b; op_sh = s; dir_right = r; logic_op = op;
    inv_b = ib; inv_out = io; dual16 = d; lane_bsel = bs;
    #1;
    exp = model(a, b, s, r, op, ib, io, d, bs);
    n_checks++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, result, exp);
    end
  endtask

  task automatic t_idle;
    apply_check("R9 zero inputs", 32'h0, 32'h0, 32'h0, 0, 2'b01, 0, 0, 0, 4'h0);
  endtask

  task automatic t_left32;
    apply_check("R1 left 4", 32'h8000_00F1, 32'h0, 32'h4, 0, 2'b01, 0, 0, 0, 4'h0);
    apply_check("R1 left 31", 32'hFFFF_FFFF, 32'h0, 32'h1F, 0, 2'b01, 0, 0, 0, 4'h0);
  endtask

  task automatic t_right32;
    apply_check("R2 right 8", 32'hF234_5678, 32'h0, 32'h8, 1, 2'b01, 0, 0, 0, 4'h0);
    apply_check("R2 right 31", 32'hFFFF_FFFF, 32'h0, 32'h1F, 1, 2'b01, 0, 0, 0, 4'h0);
  endtask

  task automatic t_ops;
    apply_check("R3 and", 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h1, 0, 2'b00, 0, 0, 0, 4'h0);
    apply_check("R3 or",  32'h0F0F_0F0F, 32'h1200_0034, 32'h3, 1, 2'b01, 0, 0, 0, 4'h0);
    apply_check("R3 xor", 32'hA5A5_A5A5, 32'hFFFF_0000, 32'h2, 0, 2'b10, 0, 0, 0, 4'h0);
    apply_check("R3 code11", 32'hA5A5_A5A5, 32'h0F0F_3C3C, 32'h5, 1, 2'b11, 0, 0, 0, 4'h0);
  endtask

  task automatic t_invb;
    apply_check("R4 and invb", 32'hFFFF_FFFF, 32'h00FF_00F0, 32'h0, 0, 2'b00, 1, 0, 0, 4'h0);
    apply_check("R4 xor invb", 32'h1234_5678, 32'h8765_4321, 32'h7, 1, 2'b10, 1, 0, 0, 4'h0);
  endtask

  task automatic t_invout;
    apply_check("R5 or invout", 32'h1234_5678, 32'h0F00_0000, 32'h4, 0, 2'b01, 0, 1, 0, 4'h0);
    apply_check("R5 both inv", 32'hCAFE_BABE, 32'h0000_FFFF, 32'h9, 1, 2'b00, 1, 1, 0, 4'h0);
  endtask

  task automatic t_dual;
    apply_check("R6 sel b00", 32'h1234_5678, 32'h0, 32'h0000_0004, 0, 2'b01, 0, 0, 1, 4'b0000);
    apply_check("R6 sel b02", 32'h1234_5678, 32'h0, 32'h0009_0003, 0, 2'b01, 0, 0, 1, 4'b1000);
    apply_check("R6 sel b31", 32'h8001_8001, 32'h0, 32'h0500_0200, 1, 2'b01, 0, 0, 1, 4'b0111);
    apply_check("R6 sel b22", 32'hABCD_EF01, 32'h0, 32'h00C6_0000, 0, 2'b01, 0, 0, 1, 4'b1010);
  endtask

  task automatic t_cross;
    apply_check("R7 left 15", 32'hFFFF_FFFF, 32'h0, 32'h0000_000F, 0, 2'b01, 0, 0, 1, 4'b0000);
    apply_check("R7 right 15", 32'hFFFF_FFFF, 32'h0, 32'h0000_000F, 1, 2'b01, 0, 0, 1, 4'b0000);
  endtask

  task automatic t_ignored;
    apply_check("R8 hi bits 32", 32'h1357_9BDF, 32'h0, 32'hFFFF_FFE3, 0, 2'b01, 0, 0, 0, 4'hF);
    apply_check("R8 hi nibble 16", 32'h1357_9BDF, 32'h0, 32'hF1F2_F3F2, 1, 2'b01, 0, 0, 1, 4'b1101);
  endtask

  task automatic t_move;
    apply_check("R9 move", 32'hDEAD_BEEF, 32'h0, 32'hFFFF_FF00, 0, 2'b01, 0, 0, 0, 4'h0);
    apply_check("R9 not", 32'hDEAD_BEEF, 32'h0, 32'h0, 1, 2'b01, 0, 1, 0, 4'h0);
  endtask

  task automatic t_sweep;
    logic [31:0] lf = 32'h1ACE_B00C;
    for (int i = 0; i < 200; i++) begin
      logic [31:0] a, b, s;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; a = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; b = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; s = lf;
      apply_check("R3 R6 sweep", a, b, s, s[5], s[9:8], s[10], s[11], s[12], lf[3:0]);
    end
  endtask

  initial begin
    fork
      begin
        t_idle; t_left32; t_right32; t_ops; t_invb; t_invout;
        t_dual; t_cross; t_ignored; t_move; t_sweep;
        done = 1'b1;
      end
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          n_checks++; n_fail++;
          $display("FAIL watchdog: actual hung expected done");
        end
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule